// File: doc/BRIEF.md
# Countdown Timer with Masked Interrupt

This block is a word-addressed timer peripheral. Software programs a limit value, then issues commands through a control register. The commands load the down-counter, stop it or start it. While the counter runs it decrements on pulses from one of four tick sources. The source is picked by a select field in the same control register. Limits above a threshold are divided down automatically, and a prescaler is switched in so that the period in source ticks stays close to the programmed value.

Each time the counter expires it reloads itself and sets a raw interrupt bit. A mask register gates that bit onto the single interrupt output. Software clears the bit by writing ones to an acknowledge offset. Reads are combinational from the presented address. Writes take effect at the rising clock edge of the cycle in which `busWr` is high. Tick sources arrive as single-cycle enable pulses in the block's own clock domain.

Top module: `countdownTimer`

## Requirements
- R1: After reset, every readable offset (0x00, 0x04, 0x08, 0x48, 0x50, 0x54) reads 0, the counter is stopped and `irqOut` is low.
- R2: The limit register at 0x00, the control register at 0x08 and the mask register at 0x48 read back the last value written to them.
- R3: Writing control with bits [1:0] = 0 loads the counter (read at 0x04) with the limit when the limit is 2048 or less. A load leaves the run state unchanged.
- R4: When the limit exceeds 2048, a load stores limit / 2048 and the running counter then steps once per 2048 selected ticks. A limit of exactly 2048 loads 2048 with no prescale.
- R5: Writing control with bits [1:0] = 2 starts the counter. While it runs, it decrements by one on each pulse of `tickEn[code-4]`, where the code in control bits [4:2] is 4 to 7. Pulses on the other tick inputs have no effect.
- R6: With a select code of 0 to 3 in bits [4:2], the running counter never changes.
- R7: A counting tick that finds the counter at 1 or 0 is an expiry. It sets raw status bit 0 (read at 0x50) and reloads the last loaded value, so the timer repeats periodically.
- R8: Writing control with bits [1:0] = 1 freezes the count. A run command issued while the count is 0 first reloads it from the current limit.
- R9: A control write with bits [1:0] = 3 changes neither the control register nor the counter state.
- R10: `irqOut` equals raw bit 0 AND mask bit 0. The offset 0x54 reads raw status AND mask.
- R11: Writing 0x4C clears the raw bits that are 1 in the written data and leaves the others. If an expiry happens in the same cycle as the acknowledge, the bit stays set.
- R12: Unmapped offsets and 0x4C read 0. Writes to 0x04, 0x50, 0x54 or unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the current cycle |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| tickEn | input | 4 | Enable pulses of the four tick sources |
| irqOut | output | 1 | Interrupt, raw bit 0 gated by mask bit 0 |

## Verification
Timing is counted from the rising edge that samples an input:
- A register write, a command or a tick is applied at that edge and appears at `busRdata` as soon as the next address is presented.
- Raw status and `irqOut` move at the same edge as the expiring tick or the acknowledge.
- A prescaled count steps only at the edge of its 2048th selected tick.

The bench changes inputs one nanosecond after each rising edge. It samples at the following falling edge, where both the behavioural model and the design have absorbed exactly the edges already seen. On every clock it compares the read data and the interrupt against that model, and it adds checks against fixed expected values at the points the requirements name.

// File: rtl/tmrPkg.sv
package tmrPkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LIMIT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_GATED = 8'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_STOP = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } opCode_e;

  // strobes from register control to the counting datapath
  typedef struct packed {
    logic              doLoad;
    logic              doStop;
    logic              doRun;
    logic              useScale;
    logic [DATA_W-1:0] loadVal;
  } dpStrobe_t;
endpackage

// File: rtl/tmrRegs.sv
module tmrRegs
  import tmrPkg::*;
#(
  parameter int PRE_LOG2 = 11,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output dpStrobe_t         stb,
  output logic [SEL_W-1:0]  srcSel,
  output logic              rawState,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] THRESH = DATA_W'(1) << PRE_LOG2;
  localparam int SEL_LSB = 2;

  logic [DATA_W-1:0] limitReg, ctrlReg, maskReg;
  logic rawBit;
  logic wrLimit, wrCtrl, wrMask, wrAck, cmdOk, scaled;
  opCode_e op;

  assign wrLimit = busWr && (busAddr == OFS_LIMIT);
  assign wrCtrl  = busWr && (busAddr == OFS_CTRL);
  assign wrMask  = busWr && (busAddr == OFS_MASK);
  assign wrAck   = busWr && (busAddr == OFS_ACK);
  assign op      = opCode_e'(busWdata[1:0]);
  assign cmdOk   = wrCtrl && (op != OP_BAD);
  assign scaled  = limitReg > THRESH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReg <= '0;
      ctrlReg  <= '0;
      maskReg  <= '0;
      rawBit   <= 1'b0;
    end else begin
      if (wrLimit) limitReg <= busWdata;
      if (cmdOk)   ctrlReg  <= busWdata;
      if (wrMask)  maskReg  <= busWdata;
      // a same-cycle expiry overrides the acknowledge
      rawBit <= expire | (rawBit & ~(wrAck & busWdata[0]));
    end
  end

  always_comb begin
    stb          = '0;
    stb.doLoad   = cmdOk && (op == OP_LOAD);
    stb.doStop   = cmdOk && (op == OP_STOP);
    stb.doRun    = cmdOk && (op == OP_RUN);
    stb.useScale = scaled;
    stb.loadVal  = scaled ? (limitReg >> PRE_LOG2) : limitReg;
  end

  assign srcSel   = ctrlReg[SEL_LSB +: SEL_W];
  assign rawState = rawBit;
  assign irqOut   = rawBit & maskReg[0];

  always_comb begin
    case (busAddr)
      OFS_LIMIT: busRdata = limitReg;
      OFS_COUNT: busRdata = count;
      OFS_CTRL:  busRdata = ctrlReg;
      OFS_MASK:  busRdata = maskReg;
      OFS_RAW:   busRdata = {{(DATA_W-1){1'b0}}, rawBit};
      OFS_GATED: busRdata = {{(DATA_W-1){1'b0}}, rawBit} & maskReg;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmrCount.sv
module tmrCount
  import tmrPkg::*;
#(
  parameter int PRE_LOG2 = 11,
  parameter int SEL_W    = 3,
  parameter int NUM_SRC  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [NUM_SRC-1:0] tickEn,
  output logic [DATA_W-1:0]  count,
  output logic               running,
  output logic               expire
);
  logic [DATA_W-1:0]   reloadVal;
  logic [PRE_LOG2-1:0] preCnt;
  logic scaleOn, selTick, effTick;

  // upper select bit set picks one of the sources, clear means no clock
  assign selTick = srcSel[SEL_W-1] ? tickEn[srcSel[SEL_W-2:0]] : 1'b0;
  assign effTick = running && selTick && (!scaleOn || (&preCnt));
  assign expire  = effTick && (count <= DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
      preCnt    <= '0;
      scaleOn   <= 1'b0;
      running   <= 1'b0;
    end else if (stb.doLoad) begin
      count     <= stb.loadVal;
      reloadVal <= stb.loadVal;
      scaleOn   <= stb.useScale;
      preCnt    <= '0;
    end else if (stb.doStop) begin
      running <= 1'b0;
    end else if (stb.doRun) begin
      running <= 1'b1;
      if (count == '0) begin
        count     <= stb.loadVal;
        reloadVal <= stb.loadVal;
        scaleOn   <= stb.useScale;
        preCnt    <= '0;
      end
    end else begin
      if (running && selTick && scaleOn) preCnt <= preCnt + 1'b1;
      if (effTick) count <= (count <= DATA_W'(1)) ? reloadVal : count - 1'b1;
    end
  end
endmodule

// File: rtl/countdownTimer.sv
module countdownTimer
  import tmrPkg::*;
#(
  parameter int PRE_LOG2 = 11,
  parameter int SEL_W    = 3,
  localparam int NUM_SRC = 1 << (SEL_W - 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] tickEn,
  output logic               irqOut
);
  dpStrobe_t         stb;
  logic [SEL_W-1:0]  srcSel;
  logic [DATA_W-1:0] count;
  logic              running, expire, rawState;

  tmrRegs #(.PRE_LOG2(PRE_LOG2), .SEL_W(SEL_W)) uRegs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .count(count),
    .expire(expire), .stb(stb), .srcSel(srcSel),
    .rawState(rawState), .irqOut(irqOut)
  );

  tmrCount #(.PRE_LOG2(PRE_LOG2), .SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) uCount (
    .clk(clk), .rstN(rstN), .stb(stb), .srcSel(srcSel), .tickEn(tickEn),
    .count(count), .running(running), .expire(expire)
  );
endmodule

// File: rtl/countdownTimerChk.sv
module countdownTimerChk
  import tmrPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input logic [DATA_W-1:0] count,
  input logic              running,
  input logic              expire,
  input logic              rawState
);
  logic ctlWr, ackOne;
  assign ctlWr  = busWr && (busAddr == OFS_CTRL);
  assign ackOne = busWr && (busAddr == OFS_ACK) && busWdata[0];

  AST_EXPIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> rawState); // R7
  AST_ACK_CLEARS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (ackOne && !expire) |=> !rawState); // R11
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rawState); // R10
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !ctlWr) |=> $stable(count)); // R8
  AST_STOP_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && busWdata[1:0] == 2'b01) |=> !running); // R8
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (running && !ctlWr && !expire) |=> (count == $past(count) || count == $past(count) - 1)); // R5
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && busWdata[1:0] == 2'b11 && !running) |=> (!running && $stable(count))); // R9
endmodule

bind countdownTimer countdownTimerChk uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .irqOut(irqOut), .count(count),
  .running(running), .expire(expire), .rawState(rawState)
);

// File: tb/tb_countdownTimer.sv
`timescale 1ns/1ps
module tb_countdownTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  tickEn = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  string curReq = "R1";

  countdownTimer dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [31:0] mLimit, mCtrl, mMask, mCount, mReload;
  logic mRaw, mRun, mScale;
  int mPre;

  always @(posedge clk) begin
    if (!rstN) begin
      mLimit = 0; mCtrl = 0; mMask = 0; mCount = 0; mReload = 0;
      mRaw = 0; mRun = 0; mScale = 0; mPre = 0;
    end else begin
      int sel;
      bit tickHit, fire, hit;
      int newLoad;
      bit big;
      sel = int'(mCtrl[4:2]);
      tickHit = (sel >= 4) ? tickEn[sel-4] : 1'b0;
      hit = 0; fire = 0;
      big = (mLimit > 32'd2048);
      newLoad = big ? int'(mLimit / 2048) : int'(mLimit);
      if (busWr && busAddr == 8'h08 && busWdata[1:0] != 2'd3) begin
        mCtrl = busWdata;
        if (busWdata[1:0] == 2'd0) begin
          mCount = newLoad; mReload = newLoad; mScale = big; mPre = 0;
        end else if (busWdata[1:0] == 2'd1) begin
          mRun = 0;
        end else begin
          mRun = 1;
          if (mCount == 0) begin
            mCount = newLoad; mReload = newLoad; mScale = big; mPre = 0;
          end
        end
      end else if (mRun && tickHit) begin
        if (mScale) begin
          if (mPre == 2047) begin mPre = 0; fire = 1; end
          else mPre = mPre + 1;
        end else fire = 1;
        if (fire) begin
          if (mCount <= 1) begin mCount = mReload; hit = 1; end
          else mCount = mCount - 1;
        end
      end
      if (busWr && busAddr == 8'h4C && busWdata[0]) mRaw = 0;
      if (hit) mRaw = 1;
      if (busWr && busAddr == 8'h00) mLimit = busWdata;
      if (busWr && busAddr == 8'h48) mMask = busWdata;
    end
  end

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      8'h00: return mLimit;
      8'h04: return mCount;
      8'h08: return mCtrl;
      8'h48: return mMask;
      8'h50: return {31'd0, mRaw};
      8'h54: return {31'd0, mRaw} & mMask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk({curReq, " rdata"}, busRdata, mRead(busAddr));
      chk({curReq, " irq"}, {31'd0, irqOut}, {31'd0, mRaw & mMask[0]});
    end
  end

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] t);
    @(posedge clk); #1;
    busWr = w; busAddr = a; busWdata = d; tickEn = t;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'b0);
  endtask
  task automatic tk(input logic [3:0] t, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h04, 32'd0, t);
  endtask
  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cyc(1'b0, a, 32'd0, 4'b0);
    @(negedge clk);
    chk(tag, busRdata, exp);
  endtask

  task automatic finishRun;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    rdChk("R1 limit", 8'h00, 0);
    rdChk("R1 count", 8'h04, 0);
    rdChk("R1 ctrl", 8'h08, 0);
    rdChk("R1 mask", 8'h48, 0);
    rdChk("R1 raw", 8'h50, 0);
    rdChk("R1 gated", 8'h54, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);

    // R2 / R3 load
    curReq = "R3";
    wr(8'h00, 5); wr(8'h08, 32'h14);
    rdChk("R3 count loaded", 8'h04, 5);
    rdChk("R2 limit readback", 8'h00, 5);
    rdChk("R2 ctrl readback", 8'h08, 32'h14);

    // R5 run on source 1 only
    curReq = "R5";
    wr(8'h08, 32'h16);
    tk(4'b1101, 3);
    rdChk("R5 other sources", 8'h04, 5);
    tk(4'b0010, 4);
    rdChk("R5 decrement", 8'h04, 1);

    // R7 expiry and reload
    curReq = "R7";
    tk(4'b0010, 1);
    rdChk("R7 reload", 8'h04, 5);
    rdChk("R7 raw set", 8'h50, 1);
    chk("R10 irq masked off", {31'd0, irqOut}, 0);

    // R10 mask
    curReq = "R10";
    wr(8'h48, 1);
    rdChk("R10 gated status", 8'h54, 1);
    chk("R10 irq high", {31'd0, irqOut}, 1);
    rdChk("R2 mask readback", 8'h48, 1);

    // R11 acknowledge
    curReq = "R11";
    wr(8'h4C, 32'hFFFF_FFFE);
    rdChk("R11 zero bit keeps", 8'h50, 1);
    wr(8'h4C, 1);
    rdChk("R11 cleared", 8'h50, 0);
    chk("R11 irq dropped", {31'd0, irqOut}, 0);

    // R8 stop, R9 illegal opcode
    curReq = "R8";
    wr(8'h08, 32'h15);
    tk(4'b0010, 3);
    rdChk("R8 frozen", 8'h04, 5);
    curReq = "R9";
    wr(8'h08, 32'h1B);
    rdChk("R9 ctrl unchanged", 8'h08, 32'h15);
    tk(4'b0010, 2);
    rdChk("R9 still stopped", 8'h04, 5);

    // R11 collision: expiry and acknowledge together
    curReq = "R11";
    wr(8'h08, 32'h16);
    tk(4'b0010, 4);
    rdChk("R11 pre-collision count", 8'h04, 1);
    cyc(1'b1, 8'h4C, 32'd1, 4'b0010);
    rdChk("R11 set wins", 8'h50, 1);
    wr(8'h4C, 1);

    // R8 run at zero reloads from limit
    curReq = "R8";
    wr(8'h08, 32'h15); wr(8'h00, 0); wr(8'h08, 32'h14);
    rdChk("R3 zero load", 8'h04, 0);
    wr(8'h00, 3); wr(8'h08, 32'h16);
    rdChk("R8 run reload", 8'h04, 3);

    // R6 disabled clock codes
    curReq = "R6";
    wr(8'h08, 32'h05); wr(8'h00, 7); wr(8'h08, 32'h04); wr(8'h08, 32'h06);
    tk(4'b1111, 5);
    rdChk("R6 code1 no ticks", 8'h04, 7);
    wr(8'h08, 32'h0E);
    tk(4'b1111, 3);
    rdChk("R6 code3 no ticks", 8'h04, 7);

    // R4 prescale
    curReq = "R4";
    wr(8'h08, 32'h1D); wr(8'h00, 32'd4096); wr(8'h08, 32'h1C);
    rdChk("R4 scaled load", 8'h04, 2);
    wr(8'h08, 32'h1E);
    tk(4'b1000, 2047);
    rdChk("R4 no step before 2048", 8'h04, 2);
    tk(4'b1000, 1);
    rdChk("R4 step at 2048", 8'h04, 1);
    tk(4'b1000, 2048);
    rdChk("R4 scaled expiry raw", 8'h50, 1);
    rdChk("R4 scaled reload", 8'h04, 2);
    wr(8'h08, 32'h1D); wr(8'h00, 32'd2048); wr(8'h08, 32'h1C);
    rdChk("R4 boundary unscaled", 8'h04, 32'd2048);

    // R12 unmapped and read-only offsets
    curReq = "R12";
    wr(8'h04, 32'hFFFF); wr(8'h50, 0); wr(8'h54, 0); wr(8'h20, 32'hFFFF_FFFF);
    rdChk("R12 unmapped read", 8'h20, 0);
    rdChk("R12 ack reads zero", 8'h4C, 0);
    rdChk("R12 raw untouched", 8'h50, 1);
    rdChk("R12 count untouched", 8'h04, 32'd2048);
    rdChk("R12 limit untouched", 8'h00, 32'd2048);

    cyc(1'b0, 8'h00, 0, 0);
    @(negedge clk);
    finishRun();
  end
endmodule